// File: doc/BRIEF.md
# Multi-Link Fabric Sprayer and Resequencer

This block sits between a frame scheduler and a set of parallel fabric links. It works on frame descriptors only. On the transmit side it decides which link carries each frame. A unicast descriptor takes the lowest-numbered link that is free in that cycle and receives the next value of an 8-bit sequence counter kept for its destination. A multicast descriptor is pinned to one link by folding its source and group identifiers into a link index, so every frame of one flow uses the same link.

On the receive side, unicast descriptors from each source pass through a 16-entry reorder ring. They are released strictly in sequence order, one per cycle. Sequence distances are computed modulo 256, so the order survives counter wraparound. A descriptor outside the acceptance window, or one that repeats a sequence number already held, is dropped and flagged. When the next expected number never arrives while later ones wait, a programmable timeout skips it and a loss counter advances. Multicast descriptors bypass the ring and are delivered in arrival order on the next cycle.

Top module: `fabric_spray_reseq`

## Requirements
- R1: A unicast request is accepted (`txReady` high) exactly when at least one bit of `linkFree` is set, and it is sent on the lowest-numbered free link.
- R2: Each destination has an 8-bit sequence counter that resets to 0. Each accepted unicast descriptor carries the current value, and the counter then advances by one. Multicast descriptors carry sequence 0 and leave all counters unchanged.
- R3: A multicast request uses link `k[1:0]^k[3:2]^k[5:4]^k[7:6]`, where `k = srcId ^ {grpId[3:0], grpId[7:4]}`. It is accepted only when that link's `linkFree` bit is set.
- R4: An accepted request appears on `txOut*` with `txOutValid` high one clock later. In a cycle with no accepted request, `txOutValid` is low on the next cycle.
- R5: Unicast descriptors of one source are delivered with consecutive sequence numbers regardless of their arrival order. A descriptor that arrives when it is the expected one is delivered two clocks after it is presented.
- R6: A unicast arrival whose distance `(rxSeq - expected) mod 256` is 16 or more, or whose ring slot is already occupied, is dropped. `rxErr` is then high for one cycle, on the clock after the arrival.
- R7: A multicast arrival is delivered on the next clock with `dlvMcast` high and its own sequence and tag, in arrival order, with no resequencing.
- R8: A source whose expected entry is missing while later entries wait receives no new arrival for that source. After `tmoLimit` further cycles, the missing number is skipped and `lossCount` increases by one. Before then, no skip occurs.
- R9: Sequence arithmetic wraps: 255 is followed by 0, both for the transmit counters and for the receive expectation.
- R10: After reset `txOutValid`, `dlvValid` and `rxErr` are low and `lossCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txValid | input | 1 | Transmit descriptor present |
| txMcast | input | 1 | Transmit descriptor is multicast |
| txDest | input | 2 | Unicast destination index |
| txSrcId | input | 8 | Multicast source identifier |
| txGrpId | input | 8 | Multicast group identifier |
| linkFree | input | 4 | One bit per link, set when the link can take a frame |
| txReady | output | 1 | Descriptor accepted this cycle |
| txOutValid | output | 1 | Registered link assignment valid |
| txOutLink | output | 2 | Chosen link |
| txOutSeq | output | 8 | Sequence tag attached |
| txOutMcast | output | 1 | Assignment is multicast |
| txOutDest | output | 2 | Destination of the assignment |
| rxValid | input | 1 | Received descriptor present |
| rxMcast | input | 1 | Received descriptor is multicast |
| rxSrc | input | 2 | Source of received descriptor |
| rxSeq | input | 8 | Sequence tag of received descriptor |
| rxTag | input | 8 | Opaque descriptor handle |
| tmoLimit | input | 16 | Cycles to wait for a missing sequence number |
| dlvValid | output | 1 | Delivered descriptor valid |
| dlvMcast | output | 1 | Delivered descriptor is multicast |
| dlvSrc | output | 2 | Source of delivered descriptor |
| dlvSeq | output | 8 | Sequence of delivered descriptor |
| dlvTag | output | 8 | Handle of delivered descriptor |
| rxErr | output | 1 | Arrival dropped as out of window or duplicate |
| lossCount | output | 16 | Number of skipped sequence numbers |

## Verification
The assertions assume that `linkFree` and the transmit request fields stay stable within a cycle. They also assume that receive sequence numbers come from a sender that never runs more than the window ahead of the receiver, except where a frame is deliberately placed outside the window. The stimulus keeps random receive traffic inside the window by sending permuted blocks of 16 numbers and idling between blocks until the ring drains. It keeps `tmoLimit` large while arrivals can be sparse, so that only the directed loss case ever triggers a skip.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef struct packed {
    logic txTake;
    logic rxStore;
    logic rxDrop;
    logic mcDeliver;
    logic relFire;
    logic skipFire;
  } fsr_strobe_t;
endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int NUM_SRC   = 4,
  parameter int SEQ_W     = 8,
  parameter int WIN       = 16,
  parameter int ID_W      = 8,
  parameter int TMO_W     = 16,
  localparam int LINK_W   = $clog2(NUM_LINKS),
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int WIN_W    = $clog2(WIN)
) (
  input  logic                            txValid,
  input  logic                            txMcast,
  input  logic [ID_W-1:0]                 txSrcId,
  input  logic [ID_W-1:0]                 txGrpId,
  input  logic [NUM_LINKS-1:0]            linkFree,
  input  logic                            rxValid,
  input  logic                            rxMcast,
  input  logic [SRC_W-1:0]                rxSrc,
  input  logic [SEQ_W-1:0]                rxSeq,
  input  logic [NUM_SRC-1:0][SEQ_W-1:0]   expSeq,
  input  logic [NUM_SRC-1:0][WIN-1:0]     slotVld,
  input  logic [NUM_SRC-1:0][TMO_W-1:0]   tmoCnt,
  input  logic [TMO_W-1:0]                tmoLimit,
  output logic                            txReady,
  output fsr_strobe_t                     st,
  output logic [LINK_W-1:0]               txLinkSel,
  output logic [SRC_W-1:0]                relSrc,
  output logic [SRC_W-1:0]                skipSrc,
  output logic [NUM_SRC-1:0]              headVld
);
  localparam logic [SEQ_W-1:0] WIN_V = SEQ_W'(WIN);
  localparam int FOLDS = ID_W / LINK_W;

  logic [LINK_W-1:0] uniLink;
  logic [LINK_W-1:0] mcLink;
  logic [ID_W-1:0]   hashKey;
  logic [SEQ_W-1:0]  rxDist;
  logic              inWin;
  logic              slotFree;
  logic              storeOk;
  logic              relAny;
  logic              skipAny;
  logic [NUM_SRC-1:0] skipCand;

  // lowest-numbered free link wins
  always_comb begin
    uniLink = '0;
    for (int i = NUM_LINKS - 1; i >= 0; i--)
      if (linkFree[i]) uniLink = LINK_W'(i);
  end

  // flow pinning: rotate group by half, mix with source, fold to link width
  always_comb begin
    hashKey = txSrcId ^ {txGrpId[ID_W/2-1:0], txGrpId[ID_W-1:ID_W/2]};
    mcLink  = '0;
    for (int i = 0; i < FOLDS; i++)
      mcLink = mcLink ^ hashKey[i*LINK_W +: LINK_W];
  end

  assign txReady   = txValid && (txMcast ? linkFree[mcLink] : (|linkFree));
  assign txLinkSel = txMcast ? mcLink : uniLink;

  // receive window classification, modular distance
  assign rxDist   = rxSeq - expSeq[rxSrc];
  assign inWin    = rxDist < WIN_V;
  assign slotFree = !slotVld[rxSrc][rxSeq[WIN_W-1:0]];
  assign storeOk  = rxValid && !rxMcast && inWin && slotFree;

  genvar gs;
  generate
    for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
      assign headVld[gs]  = slotVld[gs][expSeq[gs][WIN_W-1:0]];
      assign skipCand[gs] = !headVld[gs] && (|slotVld[gs]) &&
                            (tmoCnt[gs] >= tmoLimit) &&
                            !(storeOk && rxSrc == SRC_W'(gs));
    end
  endgenerate

  always_comb begin
    relSrc  = '0;
    relAny  = 1'b0;
    skipSrc = '0;
    skipAny = 1'b0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (headVld[s]) begin
        relSrc = SRC_W'(s);
        relAny = 1'b1;
      end
      if (skipCand[s]) begin
        skipSrc = SRC_W'(s);
        skipAny = 1'b1;
      end
    end
  end

  always_comb begin
    st.txTake    = txReady;
    st.rxStore   = storeOk;
    st.rxDrop    = rxValid && !rxMcast && !(inWin && slotFree);
    st.mcDeliver = rxValid && rxMcast;
    st.relFire   = relAny && !(rxValid && rxMcast);
    st.skipFire  = skipAny;
  end
endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int NUM_DEST  = 4,
  parameter int NUM_SRC   = 4,
  parameter int SEQ_W     = 8,
  parameter int WIN       = 16,
  parameter int TAG_W     = 8,
  parameter int TMO_W     = 16,
  parameter int LOSS_W    = 16,
  localparam int LINK_W   = $clog2(NUM_LINKS),
  localparam int DEST_W   = $clog2(NUM_DEST),
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int WIN_W    = $clog2(WIN)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  fsr_strobe_t                     st,
  input  logic [LINK_W-1:0]               txLinkSel,
  input  logic [SRC_W-1:0]                relSrc,
  input  logic [SRC_W-1:0]                skipSrc,
  input  logic [NUM_SRC-1:0]              headVld,
  input  logic                            txMcast,
  input  logic [DEST_W-1:0]               txDest,
  input  logic [SRC_W-1:0]                rxSrc,
  input  logic [SEQ_W-1:0]                rxSeq,
  input  logic [TAG_W-1:0]                rxTag,
  output logic                            txOutValid,
  output logic [LINK_W-1:0]               txOutLink,
  output logic [SEQ_W-1:0]                txOutSeq,
  output logic                            txOutMcast,
  output logic [DEST_W-1:0]               txOutDest,
  output logic [NUM_SRC-1:0][SEQ_W-1:0]   expSeq,
  output logic [NUM_SRC-1:0][WIN-1:0]     slotVld,
  output logic [NUM_SRC-1:0][TMO_W-1:0]   tmoCnt,
  output logic                            dlvValid,
  output logic                            dlvMcast,
  output logic [SRC_W-1:0]                dlvSrc,
  output logic [SEQ_W-1:0]                dlvSeq,
  output logic [TAG_W-1:0]                dlvTag,
  output logic                            rxErr,
  output logic [LOSS_W-1:0]               lossCount
);
  logic [NUM_DEST-1:0][SEQ_W-1:0]        seqCnt;
  logic [NUM_SRC-1:0][WIN-1:0][TAG_W-1:0] slotTag;
  logic [WIN_W-1:0] rxIdx;
  logic [WIN_W-1:0] relIdx;

  assign rxIdx  = rxSeq[WIN_W-1:0];
  assign relIdx = expSeq[relSrc][WIN_W-1:0];

  // transmit assignment and per-destination counters
  always_ff @(posedge clk) begin
    if (rst) begin
      seqCnt     <= '0;
      txOutValid <= 1'b0;
      txOutLink  <= '0;
      txOutSeq   <= '0;
      txOutMcast <= 1'b0;
      txOutDest  <= '0;
    end else begin
      txOutValid <= st.txTake;
      if (st.txTake) begin
        txOutLink  <= txLinkSel;
        txOutMcast <= txMcast;
        txOutDest  <= txDest;
        txOutSeq   <= txMcast ? '0 : seqCnt[txDest];
        if (!txMcast) seqCnt[txDest] <= seqCnt[txDest] + SEQ_W'(1);
      end
    end
  end

  // reorder rings, expectation, timeout and delivery
  always_ff @(posedge clk) begin
    if (rst) begin
      slotVld   <= '0;
      slotTag   <= '0;
      expSeq    <= '0;
      tmoCnt    <= '0;
      lossCount <= '0;
      rxErr     <= 1'b0;
      dlvValid  <= 1'b0;
      dlvMcast  <= 1'b0;
      dlvSrc    <= '0;
      dlvSeq    <= '0;
      dlvTag    <= '0;
    end else begin
      rxErr    <= st.rxDrop;
      dlvValid <= st.mcDeliver || st.relFire;
      if (st.rxStore) begin
        slotVld[rxSrc][rxIdx] <= 1'b1;
        slotTag[rxSrc][rxIdx] <= rxTag;
      end
      if (st.mcDeliver) begin
        dlvMcast <= 1'b1;
        dlvSrc   <= rxSrc;
        dlvSeq   <= rxSeq;
        dlvTag   <= rxTag;
      end else if (st.relFire) begin
        dlvMcast <= 1'b0;
        dlvSrc   <= relSrc;
        dlvSeq   <= expSeq[relSrc];
        dlvTag   <= slotTag[relSrc][relIdx];
        slotVld[relSrc][relIdx] <= 1'b0;
        expSeq[relSrc] <= expSeq[relSrc] + SEQ_W'(1);
      end
      if (st.skipFire) begin
        expSeq[skipSrc] <= expSeq[skipSrc] + SEQ_W'(1);
        lossCount       <= lossCount + LOSS_W'(1);
      end
      for (int s = 0; s < NUM_SRC; s++) begin
        if (headVld[s] || !(|slotVld[s]) ||
            (st.rxStore && rxSrc == SRC_W'(s)) ||
            (st.skipFire && skipSrc == SRC_W'(s)))
          tmoCnt[s] <= '0;
        else if (tmoCnt[s] != '1)
          tmoCnt[s] <= tmoCnt[s] + TMO_W'(1);
      end
    end
  end
endmodule

// File: rtl/fabric_spray_reseq.sv
module fabric_spray_reseq
  import fsr_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int NUM_DEST  = 4,
  parameter int NUM_SRC   = 4,
  parameter int SEQ_W     = 8,
  parameter int WIN       = 16,
  parameter int ID_W      = 8,
  parameter int TAG_W     = 8,
  parameter int TMO_W     = 16,
  parameter int LOSS_W    = 16,
  localparam int LINK_W   = $clog2(NUM_LINKS),
  localparam int DEST_W   = $clog2(NUM_DEST),
  localparam int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 txValid,
  input  logic                 txMcast,
  input  logic [DEST_W-1:0]    txDest,
  input  logic [ID_W-1:0]      txSrcId,
  input  logic [ID_W-1:0]      txGrpId,
  input  logic [NUM_LINKS-1:0] linkFree,
  output logic                 txReady,
  output logic                 txOutValid,
  output logic [LINK_W-1:0]    txOutLink,
  output logic [SEQ_W-1:0]     txOutSeq,
  output logic                 txOutMcast,
  output logic [DEST_W-1:0]    txOutDest,
  input  logic                 rxValid,
  input  logic                 rxMcast,
  input  logic [SRC_W-1:0]     rxSrc,
  input  logic [SEQ_W-1:0]     rxSeq,
  input  logic [TAG_W-1:0]     rxTag,
  input  logic [TMO_W-1:0]     tmoLimit,
  output logic                 dlvValid,
  output logic                 dlvMcast,
  output logic [SRC_W-1:0]     dlvSrc,
  output logic [SEQ_W-1:0]     dlvSeq,
  output logic [TAG_W-1:0]     dlvTag,
  output logic                 rxErr,
  output logic [LOSS_W-1:0]    lossCount
);
  fsr_strobe_t                 st;
  logic [LINK_W-1:0]           txLinkSel;
  logic [SRC_W-1:0]            relSrc;
  logic [SRC_W-1:0]            skipSrc;
  logic [NUM_SRC-1:0]          headVld;
  logic [NUM_SRC-1:0][SEQ_W-1:0] expSeq;
  logic [NUM_SRC-1:0][WIN-1:0]   slotVld;
  logic [NUM_SRC-1:0][TMO_W-1:0] tmoCnt;

  fsr_ctrl #(
    .NUM_LINKS(NUM_LINKS), .NUM_SRC(NUM_SRC), .SEQ_W(SEQ_W),
    .WIN(WIN), .ID_W(ID_W), .TMO_W(TMO_W)
  ) ctrl_i (
    .txValid(txValid), .txMcast(txMcast), .txSrcId(txSrcId),
    .txGrpId(txGrpId), .linkFree(linkFree), .rxValid(rxValid),
    .rxMcast(rxMcast), .rxSrc(rxSrc), .rxSeq(rxSeq), .expSeq(expSeq),
    .slotVld(slotVld), .tmoCnt(tmoCnt), .tmoLimit(tmoLimit),
    .txReady(txReady), .st(st), .txLinkSel(txLinkSel), .relSrc(relSrc),
    .skipSrc(skipSrc), .headVld(headVld)
  );

  fsr_datapath #(
    .NUM_LINKS(NUM_LINKS), .NUM_DEST(NUM_DEST), .NUM_SRC(NUM_SRC),
    .SEQ_W(SEQ_W), .WIN(WIN), .TAG_W(TAG_W), .TMO_W(TMO_W), .LOSS_W(LOSS_W)
  ) dp_i (
    .clk(clk), .rst(rst), .st(st), .txLinkSel(txLinkSel), .relSrc(relSrc),
    .skipSrc(skipSrc), .headVld(headVld), .txMcast(txMcast), .txDest(txDest),
    .rxSrc(rxSrc), .rxSeq(rxSeq), .rxTag(rxTag), .txOutValid(txOutValid),
    .txOutLink(txOutLink), .txOutSeq(txOutSeq), .txOutMcast(txOutMcast),
    .txOutDest(txOutDest), .expSeq(expSeq), .slotVld(slotVld), .tmoCnt(tmoCnt),
    .dlvValid(dlvValid), .dlvMcast(dlvMcast), .dlvSrc(dlvSrc), .dlvSeq(dlvSeq),
    .dlvTag(dlvTag), .rxErr(rxErr), .lossCount(lossCount)
  );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int NUM_LINKS = 4,
  parameter int SEQ_W     = 8,
  parameter int TAG_W     = 8,
  parameter int LOSS_W    = 16,
  localparam int LINK_W   = $clog2(NUM_LINKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 txValid,
  input logic                 txMcast,
  input logic [NUM_LINKS-1:0] linkFree,
  input logic                 txReady,
  input logic                 txOutValid,
  input logic [LINK_W-1:0]    txOutLink,
  input logic [SEQ_W-1:0]     txOutSeq,
  input logic                 txOutMcast,
  input logic                 rxValid,
  input logic                 rxMcast,
  input logic [TAG_W-1:0]     rxTag,
  input logic                 dlvValid,
  input logic                 dlvMcast,
  input logic [TAG_W-1:0]     dlvTag,
  input logic                 rxErr,
  input logic [LOSS_W-1:0]    lossCount
);
  p_ready_free_r1: assert property (@(posedge clk) disable iff (rst)
    (txValid && !txMcast) |-> (txReady == (|linkFree)));

  p_lowest_link_r1: assert property (@(posedge clk) disable iff (rst)
    (txValid && txReady && !txMcast) |=>
      (txOutValid && ((($past(linkFree) >> txOutLink) & NUM_LINKS'(1)) != '0) &&
       (($past(linkFree) & ((NUM_LINKS'(1) << txOutLink) - NUM_LINKS'(1))) == '0)));

  p_mcast_seq_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (txOutValid && txOutMcast) |-> (txOutSeq == '0));

  p_mcast_link_free_r3: assert property (@(posedge clk) disable iff (rst)
    (txValid && txReady && txMcast) |=>
      (txOutMcast && ((($past(linkFree) >> txOutLink) & NUM_LINKS'(1)) != '0)));

  p_idle_no_out_r4: assert property (@(posedge clk) disable iff (rst)
    !(txValid && txReady) |=> !txOutValid);

  p_err_cause_r6: assert property (@(posedge clk) disable iff (rst)
    rxErr |-> $past(rxValid && !rxMcast));

  p_mcast_next_r7: assert property (@(posedge clk) disable iff (rst)
    (rxValid && rxMcast) |=> (dlvValid && dlvMcast && dlvTag == $past(rxTag)));

  p_loss_step_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lossCount == $past(lossCount) ||
              lossCount == $past(lossCount) + LOSS_W'(1)));
endmodule

bind fabric_spray_reseq fsr_checker #(
  .NUM_LINKS(NUM_LINKS), .SEQ_W(SEQ_W), .TAG_W(TAG_W), .LOSS_W(LOSS_W)
) chk_i (
  .clk(clk), .rst(rst), .txValid(txValid), .txMcast(txMcast),
  .linkFree(linkFree), .txReady(txReady), .txOutValid(txOutValid),
  .txOutLink(txOutLink), .txOutSeq(txOutSeq), .txOutMcast(txOutMcast),
  .rxValid(rxValid), .rxMcast(rxMcast), .rxTag(rxTag), .dlvValid(dlvValid),
  .dlvMcast(dlvMcast), .dlvTag(dlvTag), .rxErr(rxErr), .lossCount(lossCount)
);

// File: tb/fabric_spray_reseq_tb.sv
module fabric_spray_reseq_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic txValid, txMcast;
  logic [1:0] txDest;
  logic [7:0] txSrcId, txGrpId;
  logic [3:0] linkFree;
  logic txReady, txOutValid, txOutMcast;
  logic [1:0] txOutLink, txOutDest;
  logic [7:0] txOutSeq;
  logic rxValid, rxMcast;
  logic [1:0] rxSrc;
  logic [7:0] rxSeq, rxTag;
  logic [15:0] tmoLimit;
  logic dlvValid, dlvMcast, rxErr;
  logic [1:0] dlvSrc;
  logic [7:0] dlvSeq, dlvTag;
  logic [15:0] lossCount;

  int passCnt = 0;
  int totalCnt = 0;
  bit done = 0;

  logic [7:0] modelSeq [4];
  bit   lgMc  [1024];
  logic [1:0] lgSrc [1024];
  logic [7:0] lgSeq [1024];
  logic [7:0] lgTag [1024];
  int lgN = 0;

  always #5 clk = ~clk;

  fabric_spray_reseq dut_i (
    .clk(clk), .rst(rst), .txValid(txValid), .txMcast(txMcast), .txDest(txDest),
    .txSrcId(txSrcId), .txGrpId(txGrpId), .linkFree(linkFree), .txReady(txReady),
    .txOutValid(txOutValid), .txOutLink(txOutLink), .txOutSeq(txOutSeq),
    .txOutMcast(txOutMcast), .txOutDest(txOutDest), .rxValid(rxValid),
    .rxMcast(rxMcast), .rxSrc(rxSrc), .rxSeq(rxSeq), .rxTag(rxTag),
    .tmoLimit(tmoLimit), .dlvValid(dlvValid), .dlvMcast(dlvMcast),
    .dlvSrc(dlvSrc), .dlvSeq(dlvSeq), .dlvTag(dlvTag), .rxErr(rxErr),
    .lossCount(lossCount)
  );

  always @(negedge clk) begin
    if (!rst && dlvValid && lgN < 1024) begin
      lgMc[lgN]  = dlvMcast;
      lgSrc[lgN] = dlvSrc;
      lgSeq[lgN] = dlvSeq;
      lgTag[lgN] = dlvTag;
      lgN = lgN + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  function automatic logic [1:0] lowestRef(input logic [3:0] f);
    for (int i = 0; i < 4; i++) if (f[i]) return 2'(i);
    return 2'd0;
  endfunction

  function automatic logic [1:0] hashRef(input logic [7:0] s, input logic [7:0] g);
    logic [7:0] k;
    k = s ^ {g[3:0], g[7:4]};
    return k[1:0] ^ k[3:2] ^ k[5:4] ^ k[7:6];
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic txSend(input bit mc, input logic [1:0] d, input logic [7:0] s,
                        input logic [7:0] g, input logic [3:0] f);
    bit expAcc;
    logic [1:0] expLink;
    txValid = 1; txMcast = mc; txDest = d; txSrcId = s; txGrpId = g; linkFree = f;
    expLink = mc ? hashRef(s, g) : lowestRef(f);
    expAcc  = mc ? f[expLink] : (f != 4'd0);
    #1;
    chk(txReady == expAcc, mc ? "R3 ready" : "R1 ready", int'(txReady), int'(expAcc));
    @(negedge clk);
    if (expAcc) begin
      chk(txOutValid && txOutLink == expLink, mc ? "R3 link" : "R1 link",
          int'(txOutLink), int'(expLink));
      chk(txOutSeq == (mc ? 8'd0 : modelSeq[d]) && txOutMcast == mc &&
          txOutDest == d, "R2 seq", int'(txOutSeq), int'(mc ? 8'd0 : modelSeq[d]));
      if (!mc) modelSeq[d] = modelSeq[d] + 8'd1;
    end else begin
      chk(!txOutValid, "R4 no output", int'(txOutValid), 0);
    end
    txValid = 0;
  endtask

  task automatic rxSend(input bit mc, input logic [1:0] s, input logic [7:0] q,
                        input logic [7:0] t, output bit err);
    rxValid = 1; rxMcast = mc; rxSrc = s; rxSeq = q; rxTag = t;
    @(negedge clk);
    err = rxErr;
    rxValid = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      totalCnt++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    bit e;
    int b0;
    int perm [16];
    void'($urandom(32'd4242));
    rst = 1; txValid = 0; txMcast = 0; txDest = 0; txSrcId = 0; txGrpId = 0;
    linkFree = 0; rxValid = 0; rxMcast = 0; rxSrc = 0; rxSeq = 0; rxTag = 0;
    tmoLimit = 16'd1000;
    for (int i = 0; i < 4; i++) modelSeq[i] = 8'd0;
    idle(3);
    rst = 0;
    // R10 reset state
    chk(!txOutValid && !dlvValid && !rxErr && lossCount == 0, "R10 reset",
        int'(lossCount), 0);

    // R1 directed link choice
    txSend(0, 2'd0, 8'd0, 8'd0, 4'b0110);
    txSend(0, 2'd0, 8'd0, 8'd0, 4'b1000);
    txSend(0, 2'd1, 8'd0, 8'd0, 4'b0000);
    // R3 multicast pinned and blocked
    txSend(1, 2'd0, 8'h35, 8'hC2, 4'b1111);
    txSend(1, 2'd0, 8'h35, 8'hC2, ~(4'b0001 << hashRef(8'h35, 8'hC2)));
    // R2 R9 counter wraparound on one destination
    for (int i = 0; i < 260; i++) txSend(0, 2'd1, 8'd0, 8'd0, 4'b1000);
    // random transmit traffic
    for (int i = 0; i < 400; i++)
      txSend(($urandom % 10) < 3, 2'($urandom), 8'($urandom), 8'($urandom),
             4'($urandom));
    idle(2);

    // R5 in-order latency on source 1
    rxSend(0, 2'd1, 8'd0, 8'h10, e);
    idle(1);
    chk(dlvValid && !dlvMcast && dlvSrc == 2'd1 && dlvSeq == 8'd0 && dlvTag == 8'h10,
        "R5 latency", int'(dlvSeq), 0);
    idle(2);

    // R5 out of order on source 0
    b0 = lgN;
    rxSend(0, 2'd0, 8'd2, 8'd2, e);
    rxSend(0, 2'd0, 8'd1, 8'd1, e);
    idle(3);
    chk(lgN == b0, "R5 held", lgN - b0, 0);
    rxSend(0, 2'd0, 8'd0, 8'd0, e);
    idle(6);
    chk(lgN - b0 == 3, "R5 count", lgN - b0, 3);
    for (int i = 0; i < 3; i++)
      chk(lgSrc[b0+i] == 2'd0 && lgSeq[b0+i] == 8'(i) && lgTag[b0+i] == 8'(i),
          "R5 order", int'(lgSeq[b0+i]), i);

    // R6 window and duplicate, source 0 now expects 3
    b0 = lgN;
    rxSend(0, 2'd0, 8'd19, 8'd19, e);
    chk(e, "R6 distance 16", int'(e), 1);
    rxSend(0, 2'd0, 8'd2, 8'd2, e);
    chk(e, "R6 stale", int'(e), 1);
    rxSend(0, 2'd0, 8'd18, 8'd18, e);
    chk(!e, "R6 distance 15", int'(e), 0);
    rxSend(0, 2'd0, 8'd18, 8'd99, e);
    chk(e, "R6 duplicate", int'(e), 1);
    for (int i = 3; i < 18; i++) rxSend(0, 2'd0, 8'(i), 8'(i), e);
    idle(6);
    chk(lgN - b0 == 16, "R6 count", lgN - b0, 16);
    for (int i = 0; i < 16; i++)
      chk(lgSeq[b0+i] == 8'(i + 3) && lgTag[b0+i] == 8'(i + 3), "R6 kept",
          int'(lgTag[b0+i]), i + 3);

    // R7 multicast in arrival order, no reorder
    b0 = lgN;
    rxSend(1, 2'd2, 8'd9, 8'hA1, e);
    rxSend(1, 2'd2, 8'd3, 8'hA2, e);
    idle(2);
    chk(lgN - b0 == 2 && lgMc[b0] && lgTag[b0] == 8'hA1 && lgSeq[b0] == 8'd9,
        "R7 first", int'(lgTag[b0]), 8'hA1);
    chk(lgMc[b0+1] && lgTag[b0+1] == 8'hA2 && lgSeq[b0+1] == 8'd3,
        "R7 second", int'(lgTag[b0+1]), 8'hA2);

    // R8 timeout skip on source 3
    tmoLimit = 16'd5;
    b0 = lgN;
    rxSend(0, 2'd3, 8'd1, 8'd1, e);
    idle(3);
    chk(lossCount == 0 && lgN == b0, "R8 early", int'(lossCount), 0);
    idle(10);
    chk(lossCount == 1, "R8 loss", int'(lossCount), 1);
    chk(lgN - b0 == 1 && lgSeq[b0] == 8'd1 && lgSrc[b0] == 2'd3, "R8 resume",
        int'(lgSeq[b0]), 1);
    rxSend(0, 2'd3, 8'd2, 8'd2, e);
    idle(3);
    chk(lgN - b0 == 2 && lgSeq[b0+1] == 8'd2, "R8 next", int'(lgSeq[b0+1]), 2);
    tmoLimit = 16'd1000;

    // random permuted blocks on source 2, crossing wraparound (R5, R9)
    b0 = lgN;
    for (int blk = 0; blk < 17; blk++) begin
      for (int i = 0; i < 16; i++) perm[i] = i;
      for (int i = 15; i > 0; i--) begin
        int j, t;
        j = int'($urandom % (i + 1));
        t = perm[i]; perm[i] = perm[j]; perm[j] = t;
      end
      for (int i = 0; i < 16; i++) begin
        rxSend(0, 2'd2, 8'(blk * 16 + perm[i]), 8'(blk * 16 + perm[i]), e);
        if (e) chk(0, "R6 spurious", 1, 0);
        idle(int'($urandom % 3));
      end
      idle(20);
    end
    chk(lgN - b0 == 272, "R5 random count", lgN - b0, 272);
    for (int i = 0; i < 272; i++)
      chk(!lgMc[b0+i] && lgSrc[b0+i] == 2'd2 && lgSeq[b0+i] == 8'(i) &&
          lgTag[b0+i] == 8'(i), "R9 wrap order", int'(lgSeq[b0+i]), i % 256);
    chk(lossCount == 1, "R8 no spurious loss", int'(lossCount), 1);

    done = 1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule